// File: doc/BRIEF.md
# Comma Test Pattern Source

This block sits in front of a parallel-to-serial converter and chooses what that converter sends. With the test enable low, the live parallel word passes through unchanged. With the test enable high, the live word is ignored and the block sends repeated copies of the 8b10b K28.5 comma character. The character comes in one of two complementary forms, one for each running-disparity polarity.

A select input, active low, picks how the forms are used. With the select high, every character is the positive-disparity form. With the select low, the two forms alternate from one character to the next. A rate input sets how many characters each word carries. At the slow rate a word carries one 10-bit character in its low half. At the fast rate a word carries two characters, and the low half is sent first.

The output word is loaded once per word strobe and held until the next strobe. A flag next to the word tells the serializer whether the upper half holds a character.

Top module: `comma_pattern_gen`

## Requirements
- R1: After a synchronous active-low reset, `pat_word` is all zeros and `hi_half_valid` is 0.
- R2: On a `word_strobe` cycle with `test_en` low, `pat_word` takes the value of `live_word` on the next clock edge.
- R3: Between strobes, `pat_word` keeps its value, whatever the other inputs do.
- R4: In test mode with `alt_sel_n` high, every character is the positive form. Its transmission order (bit 0 first) is 0011111010, so its value is 10'h17C. At the slow rate, bits 19:10 are zero.
- R5: In test mode at the slow rate with `alt_sel_n` low, successive words carry 10'h17C and 10'h283 in turn. 10'h283 is the negative form, whose transmission order is 1100000101.
- R6: In test mode at the fast rate with `alt_sel_n` low, the two halves of a word always hold opposite forms. The polarity sequence continues across words and across rate changes.
- R7: The first character sent after `test_en` rises is 10'h17C, whatever the polarity was before. This holds even when the strobe falls in the same cycle as the rise.
- R8: On each strobe, `hi_half_valid` takes the value of `fast_rate`.
- R9: In test mode, the value of `live_word` has no effect on `pat_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Synchronous reset, active low |
| test_en | input | 1 | Sends comma characters in place of live data |
| alt_sel_n | input | 1 | Low: forms alternate; high: positive form only |
| fast_rate | input | 1 | High: two characters per word; low: one character per word |
| word_strobe | input | 1 | Loads the next output word |
| live_word | input | 20 | Live parallel data |
| pat_word | output | 20 | Word sent to the serializer, bit 0 first |
| hi_half_valid | output | 1 | Set when bits 19:10 carry a character |

## Verification
The hardest case to reach from the ports is a polarity that is odd at the moment test mode is re-entered. That is the only case where the restart to the positive form differs from simply continuing the sequence. The stimulus gets there with a single odd slow-rate alternating strobe, followed by a fast word that keeps the parity odd. It then leaves test mode and re-enters it with the strobe in the very cycle of the rise. After that it repeats the fast word, to show that each word starts on the same polarity.

// File: rtl/comma_pkg.sv
// Package comma_pkg
// Holds the character width and the two comma character forms for the
// pattern source. Both forms are stored with bit 0 as the first bit sent.
package comma_pkg;
    localparam int CHAR_W = 10;
    // Positive form, sent as 0011111010 (bit 0 first)
    localparam logic [CHAR_W-1:0] FORM_POS = 10'h17C;
    // Negative form, sent as 1100000101 (bit 0 first)
    localparam logic [CHAR_W-1:0] FORM_NEG = 10'h283;

    // Returns the comma form for a given polarity (0 = positive)
    function automatic logic [CHAR_W-1:0] comma_form(input logic neg);
        return neg ? FORM_NEG : FORM_POS;
    endfunction
endpackage

// File: rtl/comma_phase_track.sv
// Module comma_phase_track
// Tracks the polarity of the next comma character to be sent.
// Assumes that a strobe at the fast rate sends LANES characters and a strobe
// at the slow rate sends one. A rise of test_en restarts the polarity at
// positive, including a rise that falls in the same cycle as a strobe.
module comma_phase_track #(
    parameter int LANES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic test_en,
    input  logic alt_sel_n,
    input  logic fast_rate,
    input  logic word_strobe,
    output logic start_neg
);
    localparam int FAST_STEP = LANES;

    logic test_en_q;
    logic neg_q;
    logic step_odd;

    // Keeps the test enable from the last cycle so that its rise can be seen
    always_ff @(posedge clk) begin
        if (!rst_n) test_en_q <= 1'b0;
        else        test_en_q <= test_en;
    end

    // Polarity for lane 0 in this cycle; a rise of test_en forces positive
    always_comb begin
        start_neg = (test_en && !test_en_q) ? 1'b0 : neg_q;
    end

    // Whether one strobe moves the polarity by an odd number of characters
    always_comb begin
        step_odd = fast_rate ? FAST_STEP[0] : 1'b1;
    end

    // Moves the polarity forward on each strobe in alternating test mode
    always_ff @(posedge clk) begin
        if (!rst_n)
            neg_q <= 1'b0;
        else if (word_strobe && test_en && !alt_sel_n)
            neg_q <= start_neg ^ step_odd;
        else
            neg_q <= start_neg;
    end
endmodule

// File: rtl/comma_char_mux.sv
// Module comma_char_mux
// Builds the next output word from the live data, or from one comma
// character per lane in test mode. Combinational only.
// Assumes lane 0 is the first lane sent. At the slow rate only lane 0
// carries a character and the other lanes are zero.
module comma_char_mux
    import comma_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic                      test_en,
    input  logic                      alt_sel_n,
    input  logic                      fast_rate,
    input  logic                      start_neg,
    input  logic [CHAR_W*LANES-1:0]   live_word,
    output logic [CHAR_W*LANES-1:0]   next_word
);
    localparam int WORD_W = CHAR_W * LANES;

    logic [WORD_W-1:0] test_word;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam logic LANE_ODD = g[0];
        logic lane_neg;
        logic lane_on;
        // Picks this lane's polarity and whether it carries a character
        always_comb begin
            lane_neg = alt_sel_n ? 1'b0 : (start_neg ^ LANE_ODD);
            lane_on  = fast_rate || (g == 0);
            test_word[g*CHAR_W +: CHAR_W] = lane_on ? comma_form(lane_neg)
                                                    : '0;
        end
    end

    // Chooses between the live data and the comma pattern
    always_comb begin
        next_word = test_en ? test_word : live_word;
    end
endmodule

// File: rtl/comma_pattern_gen.sv
// Module comma_pattern_gen
// Top level of the comma test pattern source. Loads a new output word on
// each word strobe and holds it between strobes.
// Assumes that word_strobe is synchronous to clk and lasts one cycle per word.
module comma_pattern_gen
    import comma_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    test_en,
    input  logic                    alt_sel_n,
    input  logic                    fast_rate,
    input  logic                    word_strobe,
    input  logic [CHAR_W*LANES-1:0] live_word,
    output logic [CHAR_W*LANES-1:0] pat_word,
    output logic                    hi_half_valid
);
    localparam int WORD_W = CHAR_W * LANES;

    logic              start_neg;
    logic [WORD_W-1:0] next_word;

    comma_phase_track #(.LANES(LANES)) i_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .test_en     (test_en),
        .alt_sel_n   (alt_sel_n),
        .fast_rate   (fast_rate),
        .word_strobe (word_strobe),
        .start_neg   (start_neg)
    );

    comma_char_mux #(.LANES(LANES)) i_mux (
        .test_en   (test_en),
        .alt_sel_n (alt_sel_n),
        .fast_rate (fast_rate),
        .start_neg (start_neg),
        .live_word (live_word),
        .next_word (next_word)
    );

    // Output register, loaded only on a word strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pat_word      <= '0;
            hi_half_valid <= 1'b0;
        end else if (word_strobe) begin
            pat_word      <= next_word;
            hi_half_valid <= fast_rate;
        end
    end
endmodule

// File: rtl/comma_pattern_chk.sv
// Module comma_pattern_chk
// Checks the pattern source's port behaviour over time. Attached to every
// comma_pattern_gen instance by the bind statement at the end of this file.
// Assumes the default two-lane layout of 10-bit characters.
module comma_pattern_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        test_en,
    input logic        alt_sel_n,
    input logic        fast_rate,
    input logic        word_strobe,
    input logic [19:0] live_word,
    input logic [19:0] pat_word,
    input logic        hi_half_valid
);
    assert_live_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (word_strobe && !test_en) |=> (pat_word == $past(live_word)));

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !word_strobe |=> $stable(pat_word));

    assert_fixed_form_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (word_strobe && test_en && alt_sel_n) |=> (pat_word[9:0] == 10'h17C));

    assert_halves_opposite_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (word_strobe && test_en && !alt_sel_n && fast_rate)
            |=> (pat_word[19:10] == ~pat_word[9:0]));

    assert_restart_pos_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (word_strobe && $rose(test_en)) |=> (pat_word[9:0] == 10'h17C));

    assert_valid_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        word_strobe |=> (hi_half_valid == $past(fast_rate)));
endmodule

bind comma_pattern_gen comma_pattern_chk i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .test_en       (test_en),
    .alt_sel_n     (alt_sel_n),
    .fast_rate     (fast_rate),
    .word_strobe   (word_strobe),
    .live_word     (live_word),
    .pat_word      (pat_word),
    .hi_half_valid (hi_half_valid)
);

// File: tb/test_comma_pattern_gen.sv
// Bench for comma_pattern_gen: a walked vector table, then directed tests.
module test_comma_pattern_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        test_en = 1'b0;
    logic        alt_sel_n = 1'b1;
    logic        fast_rate = 1'b0;
    logic        word_strobe = 1'b0;
    logic [19:0] live_word = '0;
    logic [19:0] pat_word;
    logic        hi_half_valid;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    comma_pattern_gen i_comma_pattern_gen (
        .clk           (clk),
        .rst_n         (rst_n),
        .test_en       (test_en),
        .alt_sel_n     (alt_sel_n),
        .fast_rate     (fast_rate),
        .word_strobe   (word_strobe),
        .live_word     (live_word),
        .pat_word      (pat_word),
        .hi_half_valid (hi_half_valid)
    );

    // Vector fields: test_en, alt_sel_n, fast_rate, live word, expected word, expected flag
    typedef struct packed {
        logic        te;
        logic        alt_n;
        logic        fast;
        logic [19:0] live;
        logic [19:0] exp_w;
        logic        exp_v;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 1'b1, 20'hABCDE, 20'hABCDE, 1'b1}, // R2 live, fast
        '{1'b0, 1'b1, 1'b0, 20'h12345, 20'h12345, 1'b0}, // R2 live, slow
        '{1'b1, 1'b1, 1'b1, 20'hFFFFF, 20'h5F17C, 1'b1}, // R4 fixed, fast
        '{1'b1, 1'b1, 1'b0, 20'h0F0F0, 20'h0017C, 1'b0}, // R4 fixed, slow
        '{1'b1, 1'b0, 1'b0, 20'h00000, 20'h0017C, 1'b0}, // R5 alt slow, first
        '{1'b1, 1'b0, 1'b0, 20'h55555, 20'h00283, 1'b0}, // R5 alt slow, second
        '{1'b1, 1'b0, 1'b0, 20'hAAAAA, 20'h0017C, 1'b0}, // R5 alt slow, third
        '{1'b1, 1'b0, 1'b1, 20'h33333, 20'h5F283, 1'b1}, // R6 fast, odd polarity
        '{1'b0, 1'b0, 1'b0, 20'h00000, 20'h00000, 1'b0}, // R2 leave test mode
        '{1'b1, 1'b0, 1'b1, 20'hCCCCC, 20'hA0D7C, 1'b1}, // R7 restart on rise with strobe
        '{1'b1, 1'b0, 1'b1, 20'h0000F, 20'hA0D7C, 1'b1}, // R6 fast, repeats
        '{1'b1, 1'b0, 1'b0, 20'hF0000, 20'h0017C, 1'b0}  // R5 back to slow
    };

    task automatic check(input string req, input logic [20:0] act, input logic [20:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        #4_000_000;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset", {hi_half_valid, pat_word}, 21'h0);
        rst_n = 1'b1;

        foreach (VECS[i]) begin
            @(negedge clk);
            test_en = VECS[i].te;
            alt_sel_n = VECS[i].alt_n;
            fast_rate = VECS[i].fast;
            live_word = VECS[i].live;
            word_strobe = 1'b1;
            @(negedge clk);
            word_strobe = 1'b0;
            check($sformatf("R2/R4-R9 vector %0d", i), {hi_half_valid, pat_word},
                  {VECS[i].exp_v, VECS[i].exp_w});
            live_word = ~VECS[i].live;
            fast_rate = ~VECS[i].fast;
            @(negedge clk);
            check($sformatf("R3 hold vector %0d", i), {hi_half_valid, pat_word},
                  {VECS[i].exp_v, VECS[i].exp_w});
        end

        // R9: live data changes under test mode do not reach the output
        @(negedge clk);
        test_en = 1'b1; alt_sel_n = 1'b1; fast_rate = 1'b1;
        live_word = 20'h00000; word_strobe = 1'b1;
        @(negedge clk);
        live_word = 20'hFFFFF;
        @(negedge clk);
        word_strobe = 1'b0;
        check("R9 live ignored", {hi_half_valid, pat_word}, {1'b1, 20'h5F17C});

        // R8: flag follows the rate sampled at the strobe
        @(negedge clk);
        fast_rate = 1'b0; word_strobe = 1'b1;
        @(negedge clk);
        word_strobe = 1'b0;
        check("R8 flag slow", {20'h0, hi_half_valid}, 21'h0);

        // R1: reset in the middle of a run clears the output
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid-run", {hi_half_valid, pat_word}, 21'h0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule